// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Unit

This block sits beside the register file of a five-stage pipeline. It decides, for the instruction now in decode, where each of its two source operands comes from. Each source register number is compared with the destination register numbers of the instructions further down the pipeline, which are held in the later pipeline registers. When a later stage will write the register being read, that stage's in-flight data replaces the register-file read value. The two operands are resolved separately, and when more than one stage matches, the nearest stage supplies the value.

Loads follow the delayed-load rule. A load that is still in the nearest downstream stage has not fetched its data yet, so that stage is left out of the comparison. The instruction right after a load therefore sees the register's earlier contents: either an older in-flight value or the register-file value. No stall is ever needed. The block is purely combinational. Per operand it gives the chosen data and a select code that names the source.

Top module: `fwd_unit`

## Requirements
- R1: If no downstream stage qualifies for an operand, its select code is 0 and the operand equals the matching register-file read port (first source uses read port 1, second source uses read port 2).
- R2: A downstream stage qualifies for a source only when its write enable is 1, its destination number is non-zero and its destination equals the source register number.
- R3: A source register number of 0 always yields select 0 and the register-file value, even if a stage writes register 0.
- R4: A stage whose write enable is 0 is never selected, whatever its destination number.
- R5: When several stages qualify, the one with the lowest stage index (index 0 = nearest, the stage holding the instruction just ahead) is selected.
- R6: A stage whose load flag is 1 and whose index is below LOAD_READY_STAGE (default 1, meaning only stage 0) does not qualify. Selection falls through to an older qualifying stage or to the register file.
- R7: A load in a stage at or beyond LOAD_READY_STAGE qualifies like any other write.
- R8: The two operands are resolved independently: the stimulus of one source never changes the other operand's select or data.
- R9: Select code k (1 to NUM_STAGES) means the operand equals the data of stage index k-1. Code 0 means the register file. No code above NUM_STAGES is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | REG_ADDR_W | First source register number of the decode-stage instruction |
| idRt | input | REG_ADDR_W | Second source register number of the decode-stage instruction |
| rfRd1 | input | DATA_W | Register-file read data for the first source |
| rfRd2 | input | DATA_W | Register-file read data for the second source |
| stgDest | input | NUM_STAGES×REG_ADDR_W | Destination register number per downstream stage, index 0 nearest |
| stgRegWr | input | NUM_STAGES | Register write enable per downstream stage |
| stgIsLoad | input | NUM_STAGES | Load flag per downstream stage |
| stgData | input | NUM_STAGES×DATA_W | Result data held per downstream stage |
| opA | output | DATA_W | Resolved first operand |
| opB | output | DATA_W | Resolved second operand |
| selA | output | SEL_W (3) | Source code of the first operand |
| selB | output | SEL_W (3) | Source code of the second operand |

## Verification
The bench builds the unit with its defaults: three downstream stages, five-bit register numbers, 32-bit data and LOAD_READY_STAGE of 1, so only the nearest stage hides a load. With three stages, every mix of write enable, match and load flag across all stages (512 patterns) can be swept in full. The two sources are given complementary match patterns in that sweep. Random traffic then draws register numbers from a pool of four small values that includes register 0, so multi-stage collisions, zero-register writes and loads in every position occur often. These are compared with a behavioural model every cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // width of a per-operand source code; NUM_STAGES must stay below 2**SEL_W
  localparam int SEL_W = 3;
  localparam int NUM_OPS = 2;

  // strobes from control to datapath: one source code and one hit flag per operand
  typedef struct packed {
    logic [NUM_OPS-1:0][SEL_W-1:0] srcSel;
    logic [NUM_OPS-1:0]            fwdHit;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_ADDR_W       = 5,
  parameter int NUM_STAGES       = 3,
  parameter int LOAD_READY_STAGE = 1
) (
  input  logic [REG_ADDR_W-1:0]                 srcReg,
  input  logic [NUM_STAGES-1:0][REG_ADDR_W-1:0] stgDest,
  input  logic [NUM_STAGES-1:0]                 stgRegWr,
  input  logic [NUM_STAGES-1:0]                 stgIsLoad,
  output logic [fwd_pkg::SEL_W-1:0]             srcSel,
  output logic                                  fwdHit
);
  import fwd_pkg::*;

  logic [NUM_STAGES-1:0] eligible;

  // per-stage qualification; loads too young to carry data drop out
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam bit LOAD_PENDING = (s < LOAD_READY_STAGE);
    logic destHit;
    logic loadBlocked;
    assign destHit     = (stgDest[s] == srcReg) && (stgDest[s] != '0);
    assign loadBlocked = LOAD_PENDING && stgIsLoad[s];
    assign eligible[s] = stgRegWr[s] && destHit && !loadBlocked;
  end

  // priority: scan oldest to nearest so the nearest eligible stage wins
  always_comb begin
    srcSel = '0;
    for (int s = NUM_STAGES - 1; s >= 0; s--) begin
      if (eligible[s]) srcSel = SEL_W'(s + 1);
    end
  end

  assign fwdHit = |eligible;
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl #(
  parameter int REG_ADDR_W       = 5,
  parameter int NUM_STAGES       = 3,
  parameter int LOAD_READY_STAGE = 1
) (
  input  logic [REG_ADDR_W-1:0]                 idRs,
  input  logic [REG_ADDR_W-1:0]                 idRt,
  input  logic [NUM_STAGES-1:0][REG_ADDR_W-1:0] stgDest,
  input  logic [NUM_STAGES-1:0]                 stgRegWr,
  input  logic [NUM_STAGES-1:0]                 stgIsLoad,
  output fwd_pkg::fwdStrobe_t                   strobe
);
  import fwd_pkg::*;

  logic [NUM_OPS-1:0][REG_ADDR_W-1:0] srcRegs;
  assign srcRegs[0] = idRs;
  assign srcRegs[1] = idRt;

  // one independent matcher per source operand
  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    fwd_match #(
      .REG_ADDR_W      (REG_ADDR_W),
      .NUM_STAGES      (NUM_STAGES),
      .LOAD_READY_STAGE(LOAD_READY_STAGE)
    ) u_match (
      .srcReg   (srcRegs[op]),
      .stgDest  (stgDest),
      .stgRegWr (stgRegWr),
      .stgIsLoad(stgIsLoad),
      .srcSel   (strobe.srcSel[op]),
      .fwdHit   (strobe.fwdHit[op])
    );
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath #(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 3
) (
  input  fwd_pkg::fwdStrobe_t               strobe,
  input  logic [DATA_W-1:0]                 rfRd1,
  input  logic [DATA_W-1:0]                 rfRd2,
  input  logic [NUM_STAGES-1:0][DATA_W-1:0] stgData,
  output logic [DATA_W-1:0]                 opA,
  output logic [DATA_W-1:0]                 opB
);
  import fwd_pkg::*;

  logic [NUM_OPS-1:0][DATA_W-1:0] rfIn;
  logic [NUM_OPS-1:0][DATA_W-1:0] opOut;

  assign rfIn[0] = rfRd1;
  assign rfIn[1] = rfRd2;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
    logic [DATA_W-1:0] stgPick;
    always_comb begin
      stgPick = '0;
      for (int s = 0; s < NUM_STAGES; s++) begin
        if (strobe.srcSel[op] == SEL_W'(s + 1)) stgPick = stgData[s];
      end
    end
    assign opOut[op] = strobe.fwdHit[op] ? stgPick : rfIn[op];
  end

  assign opA = opOut[0];
  assign opB = opOut[1];
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int DATA_W           = 32,
  parameter int REG_ADDR_W       = 5,
  parameter int NUM_STAGES       = 3,
  parameter int LOAD_READY_STAGE = 1
) (
  input  logic [REG_ADDR_W-1:0]                 idRs,
  input  logic [REG_ADDR_W-1:0]                 idRt,
  input  logic [DATA_W-1:0]                     rfRd1,
  input  logic [DATA_W-1:0]                     rfRd2,
  input  logic [NUM_STAGES-1:0][REG_ADDR_W-1:0] stgDest,
  input  logic [NUM_STAGES-1:0]                 stgRegWr,
  input  logic [NUM_STAGES-1:0]                 stgIsLoad,
  input  logic [NUM_STAGES-1:0][DATA_W-1:0]     stgData,
  output logic [DATA_W-1:0]                     opA,
  output logic [DATA_W-1:0]                     opB,
  output logic [fwd_pkg::SEL_W-1:0]             selA,
  output logic [fwd_pkg::SEL_W-1:0]             selB
);
  import fwd_pkg::*;

  fwdStrobe_t strobe;

  fwd_ctrl #(
    .REG_ADDR_W      (REG_ADDR_W),
    .NUM_STAGES      (NUM_STAGES),
    .LOAD_READY_STAGE(LOAD_READY_STAGE)
  ) u_ctrl (
    .idRs     (idRs),
    .idRt     (idRt),
    .stgDest  (stgDest),
    .stgRegWr (stgRegWr),
    .stgIsLoad(stgIsLoad),
    .strobe   (strobe)
  );

  fwd_datapath #(
    .DATA_W    (DATA_W),
    .NUM_STAGES(NUM_STAGES)
  ) u_dp (
    .strobe (strobe),
    .rfRd1  (rfRd1),
    .rfRd2  (rfRd2),
    .stgData(stgData),
    .opA    (opA),
    .opB    (opB)
  );

  assign selA = strobe.srcSel[0];
  assign selB = strobe.srcSel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int DATA_W           = 32,
  parameter int REG_ADDR_W       = 5,
  parameter int NUM_STAGES       = 3,
  parameter int LOAD_READY_STAGE = 1
) (
  input logic [REG_ADDR_W-1:0]                 idRs,
  input logic [REG_ADDR_W-1:0]                 idRt,
  input logic [DATA_W-1:0]                     rfRd1,
  input logic [DATA_W-1:0]                     rfRd2,
  input logic [NUM_STAGES-1:0][REG_ADDR_W-1:0] stgDest,
  input logic [NUM_STAGES-1:0]                 stgRegWr,
  input logic [NUM_STAGES-1:0]                 stgIsLoad,
  input logic [NUM_STAGES-1:0][DATA_W-1:0]     stgData,
  input logic [DATA_W-1:0]                     opA,
  input logic [DATA_W-1:0]                     opB,
  input logic [fwd_pkg::SEL_W-1:0]             selA,
  input logic [fwd_pkg::SEL_W-1:0]             selB
);
  import fwd_pkg::*;

  always_comb begin
    // R9
    sel_range_chk: assert (int'(selA) <= NUM_STAGES && int'(selB) <= NUM_STAGES);
    // R3
    if (idRs == '0) zero_src_a_chk: assert (selA == '0);
    // R3
    if (idRt == '0) zero_src_b_chk: assert (selB == '0);
    // R1
    if (selA == '0) rf_path_a_chk: assert (opA == rfRd1);
    // R1
    if (selB == '0) rf_path_b_chk: assert (opB == rfRd2);
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (selA == SEL_W'(s + 1)) begin
        // R9
        stage_data_a_chk: assert (opA == stgData[s]);
        // R2
        stage_qual_a_chk: assert (stgRegWr[s] && stgDest[s] == idRs);
        // R6
        if (s < LOAD_READY_STAGE) young_load_a_chk: assert (!stgIsLoad[s]);
      end
      if (selB == SEL_W'(s + 1)) begin
        // R9
        stage_data_b_chk: assert (opB == stgData[s]);
        // R2
        stage_qual_b_chk: assert (stgRegWr[s] && stgDest[s] == idRt);
        // R6
        if (s < LOAD_READY_STAGE) young_load_b_chk: assert (!stgIsLoad[s]);
      end
    end
  end
endmodule

bind fwd_unit fwd_unit_chk #(
  .DATA_W          (DATA_W),
  .REG_ADDR_W      (REG_ADDR_W),
  .NUM_STAGES      (NUM_STAGES),
  .LOAD_READY_STAGE(LOAD_READY_STAGE)
) u_chk (
  .idRs     (idRs),
  .idRt     (idRt),
  .rfRd1    (rfRd1),
  .rfRd2    (rfRd2),
  .stgDest  (stgDest),
  .stgRegWr (stgRegWr),
  .stgIsLoad(stgIsLoad),
  .stgData  (stgData),
  .opA      (opA),
  .opB      (opB),
  .selA     (selA),
  .selB     (selB)
);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  localparam int DW  = 32;
  localparam int AW  = 5;
  localparam int NS  = 3;
  localparam int LRS = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 8 ns period

  logic [AW-1:0]          idRs, idRt;
  logic [DW-1:0]          rfRd1, rfRd2;
  logic [NS-1:0][AW-1:0]  stgDest;
  logic [NS-1:0]          stgRegWr, stgIsLoad;
  logic [NS-1:0][DW-1:0]  stgData;
  logic [DW-1:0]          opA, opB;
  logic [2:0]             selA, selB;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  fwd_unit #(.DATA_W(DW), .REG_ADDR_W(AW), .NUM_STAGES(NS), .LOAD_READY_STAGE(LRS)) u0 (
    .idRs(idRs), .idRt(idRt), .rfRd1(rfRd1), .rfRd2(rfRd2),
    .stgDest(stgDest), .stgRegWr(stgRegWr), .stgIsLoad(stgIsLoad), .stgData(stgData),
    .opA(opA), .opB(opB), .selA(selA), .selB(selB)
  );

  // behavioural model: stage list walked nearest first
  function automatic int refSel(input logic [AW-1:0] src);
    for (int s = 0; s < NS; s++) begin
      if (stgRegWr[s] === 1'b1 && src != 0 && stgDest[s] == src &&
          !(stgIsLoad[s] && s < LRS))
        return s + 1;
    end
    return 0;
  endfunction

  function automatic logic [DW-1:0] refData(input int sel, input logic [DW-1:0] rf);
    if (sel == 0) return rf;
    return stgData[sel-1];
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // sample away from the driving edge and compare all four outputs
  task automatic settleAndCheck(input string tagSel, input string tagData);
    int eA, eB;
    @(negedge clk);
    eA = refSel(idRs);
    eB = refSel(idRt);
    chk({tagSel, " selA"}, DW'(selA), DW'(eA));
    chk({tagSel, " selB"}, DW'(selB), DW'(eB));
    chk({tagData, " opA"}, opA, refData(eA, rfRd1));
    chk({tagData, " opB"}, opB, refData(eB, rfRd2));
    @(posedge clk);
  endtask

  task automatic clearStages();
    stgDest = '0; stgRegWr = '0; stgIsLoad = '0;
    for (int s = 0; s < NS; s++) stgData[s] = 32'hD000_0000 + DW'(s + 1) * 32'h111;
    rfRd1 = 32'hAAAA_0001; rfRd2 = 32'hBBBB_0002;
  endtask

  initial begin
    clearStages();
    idRs = 5'd0; idRt = 5'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1: idle pipeline, all values from the register file
    idRs = 5'd7; idRt = 5'd8;
    settleAndCheck("R1", "R1");

    // R3: writes to register 0 are never forwarded
    stgDest = {5'd0, 5'd0, 5'd0}; stgRegWr = 3'b111; idRs = 5'd0; idRt = 5'd0;
    settleAndCheck("R3", "R3");

    // R4: matching destination with write disabled
    clearStages(); stgDest = {5'd7, 5'd7, 5'd7}; stgRegWr = 3'b000; idRs = 5'd7;
    settleAndCheck("R4", "R4");

    // R5: all three match, nearest wins; then only the two older ones
    stgRegWr = 3'b111;
    settleAndCheck("R5", "R9");
    stgRegWr = 3'b110;
    settleAndCheck("R5", "R9");

    // R6: load in nearest stage is skipped, falls to stage 1 or RF
    stgIsLoad = 3'b001;
    stgRegWr = 3'b111;
    settleAndCheck("R6", "R6");
    stgRegWr = 3'b001;
    settleAndCheck("R6", "R6");

    // R7: loads in older stages forward normally
    stgIsLoad = 3'b110; stgRegWr = 3'b110;
    settleAndCheck("R7", "R7");

    // R2 and R8: full sweep of write/match/load masks, rt gets complementary matches
    for (int w = 0; w < 8; w++)
      for (int m = 0; m < 8; m++)
        for (int l = 0; l < 8; l++) begin
          clearStages();
          idRs = 5'd9; idRt = 5'd10;
          for (int s = 0; s < NS; s++) begin
            stgDest[s] = m[s] ? 5'd9 : 5'd10;
            stgData[s] = 32'h1000 * DW'(w) + 32'h100 * DW'(m) + 32'h10 * DW'(l) + DW'(s);
          end
          stgRegWr = 3'(w); stgIsLoad = 3'(l);
          settleAndCheck("R2", "R8");
        end

    // R5 and R9: random traffic over a small register pool including 0
    for (int n = 0; n < 3000; n++) begin
      idRs = 5'($urandom_range(0, 3));
      idRt = 5'($urandom_range(0, 3));
      rfRd1 = $urandom; rfRd2 = $urandom;
      for (int s = 0; s < NS; s++) begin
        stgDest[s] = 5'($urandom_range(0, 3));
        stgData[s] = $urandom;
      end
      stgRegWr = 3'($urandom); stgIsLoad = 3'($urandom);
      settleAndCheck("R5", "R9");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule